// File: doc/BRIEF.md
# Secondary Interrupt Cascade Controller

This block gathers a set of peripheral interrupt lines (32 by default) and folds them into one cascaded interrupt request for a primary controller. Each line is brought into the clock domain through a two-stage synchroniser and then qualified by a per-line sense bit (active high or active low) and a per-line mode bit (level or edge). Edge-mode lines latch a pending flag that software acknowledges; level-mode lines are pending for as long as their qualified input is active.

Software reaches the block through a small synchronous register port: a direct enable register, separate one-to-set and one-to-clear enable registers for atomic updates, the mode and sense registers, a one-to-clear acknowledge register, a read-only view of pending and enabled lines, and a wake mask. A priority picker presents the lowest pending enabled line index with a valid flag so the handler can dispatch without scanning. While the low-power input is high, a wake output reports any pending line selected by the wake mask, independent of the normal enables.

Top module: `sec_irq_cascade`

## Requirements
- R1: A write to offset 1 sets every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged; the enable register reads back at offset 0, which can also be written directly.
- R2: A write to offset 2 clears every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R3: The sense register at offset 4 inverts a line when its bit is 1 (active low or falling edge) and takes it as active high or rising edge when its bit is 0.
- R4: The mode register at offset 3 makes a line edge-triggered when its bit is 1 and level-sensitive when 0; an edge-mode line stays pending after its input returns inactive.
- R5: A write to offset 5 with a bit set clears that line's latched edge pending flag; on a level-mode line whose input is still active it has no lasting effect.
- R6: Offset 6 reads pending AND enabled lines; writes to it have no effect.
- R7: `pick_idx` gives the lowest index among the bits of the offset-6 view, and `pick_valid` is 1 exactly when that view is non-zero.
- R8: `cascade_irq` is 1 exactly when at least one enabled line is pending.
- R9: `wake_req` is 1 exactly when `low_power` is 1 and some pending line has its bit set in the wake mask at offset 7, whatever the enable register holds.
- R10: After reset the enable, mode, sense, wake mask and pending state all read as zero and `cascade_irq`, `pick_valid` and `wake_req` are 0.
- R11: If an acknowledge of an edge-mode line is written in the same cycle in which a new qualified edge on that line is detected, the line remains pending.
- R12: An input change driven before clock edge k shows in the offset-6 view of a level-mode line after edge k+1 and not before; for an edge-mode line it shows after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_LINES | Asynchronous peripheral interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for writes and reads |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| low_power | input | 1 | High while the system is in its low-power state |
| cascade_irq | output | 1 | Cascaded request to the primary controller |
| pick_idx | output | IDX_W | Lowest pending enabled line index |
| pick_valid | output | 1 | `pick_idx` is meaningful |
| wake_req | output | 1 | Wake request during low power |

## Verification
The collision that matters is an acknowledge write landing in the very cycle that a new edge is detected on the same line: the detection must win, or an interrupt is silently lost. The bench provokes it by driving an edge on a line and placing the acknowledge write exactly two clock edges later, when the synchronised edge reaches the latch, then judges that the line is still pending and that a later lone acknowledge clears it. A second overlap, enable set and clear against polarity flips that manufacture edges, is exercised by random register traffic checked against a bench model after each operation settles.

// File: rtl/sec_irq_pkg.sv
// Shared register offsets for the secondary interrupt cascade controller.
// Assumes a 3-bit word offset on the register port.
package sec_irq_pkg;
    typedef enum logic [2:0] {
        OFS_ENA     = 3'd0,
        OFS_ENA_SET = 3'd1,
        OFS_ENA_CLR = 3'd2,
        OFS_MODE    = 3'd3,
        OFS_SENSE   = 3'd4,
        OFS_ACK     = 3'd5,
        OFS_VIEW    = 3'd6,
        OFS_WAKE    = 3'd7
    } sec_irq_ofs_e;
endpackage

// File: rtl/sec_irq_sync.sv
// Two-stage synchroniser, one per interrupt line.
// Assumes inputs are asynchronous single-bit levels; adds two cycles of latency.
module sec_irq_sync #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] async_i,
    output logic [NUM_LINES-1:0] sync_o
);
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            logic meta_q;
            logic stab_q;
            // Capture the raw line and then re-sample it into the stable stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[g] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/sec_irq_regs.sv
// Register file: enables (direct, set, clear), mode, sense, wake mask,
// acknowledge strobe and read mux. Assumes one access per cycle and
// NUM_LINES <= DATA_W; unused upper read bits return zero.
module sec_irq_regs
    import sec_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [2:0]           addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_LINES-1:0] view_i,
    output logic [NUM_LINES-1:0] ena_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] sense_o,
    output logic [NUM_LINES-1:0] wake_o,
    output logic [NUM_LINES-1:0] ack_o,
    output logic [DATA_W-1:0]    rdata_o
);
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] ena_q, mode_q, sense_q, wake_q;

    assign wbits = wdata_i[NUM_LINES-1:0];

    // Update the configuration registers from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q   <= '0;
            mode_q  <= '0;
            sense_q <= '0;
            wake_q  <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_ENA:     ena_q   <= wbits;
                OFS_ENA_SET: ena_q   <= ena_q | wbits;
                OFS_ENA_CLR: ena_q   <= ena_q & ~wbits;
                OFS_MODE:    mode_q  <= wbits;
                OFS_SENSE:   sense_q <= wbits;
                OFS_WAKE:    wake_q  <= wbits;
                default:     ;
            endcase
        end
    end

    // Acknowledge is a single-cycle strobe towards the pending logic.
    always_comb begin
        ack_o = '0;
        if (wr_i && addr_i == OFS_ACK) ack_o = wbits;
    end

    // Read mux; the set and clear offsets both show the enable register.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_ENA, OFS_ENA_SET, OFS_ENA_CLR: rdata_o[NUM_LINES-1:0] = ena_q;
            OFS_MODE:  rdata_o[NUM_LINES-1:0] = mode_q;
            OFS_SENSE: rdata_o[NUM_LINES-1:0] = sense_q;
            OFS_VIEW:  rdata_o[NUM_LINES-1:0] = view_i;
            OFS_WAKE:  rdata_o[NUM_LINES-1:0] = wake_q;
            default:   rdata_o = '0;
        endcase
    end

    assign ena_o   = ena_q;
    assign mode_o  = mode_q;
    assign sense_o = sense_q;
    assign wake_o  = wake_q;

    // R1
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_ENA_SET) |=> ((ena_q & $past(wbits)) == $past(wbits)));
    // R2
    ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_ENA_CLR) |=> ((ena_q & $past(wbits)) == '0));
    // R1 R2
    ena_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == OFS_ENA_SET || addr_i == OFS_ENA_CLR))
        |=> ((ena_q & ~$past(wbits)) == ($past(ena_q) & ~$past(wbits))));
endmodule

// File: rtl/sec_irq_pend.sv
// Pending logic: qualifies synchronised lines by sense, latches edges for
// edge-mode lines until acknowledged, passes level lines straight through.
// Assumes inputs are already synchronous; a new edge outranks an acknowledge.
module sec_irq_pend #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic [NUM_LINES-1:0] mode_i,
    input  logic [NUM_LINES-1:0] sense_i,
    input  logic [NUM_LINES-1:0] ack_i,
    input  logic [NUM_LINES-1:0] ena_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] view_o
);
    logic [NUM_LINES-1:0] qual, prev_q, edge_w, latch_q;

    assign qual   = line_i ^ sense_i;
    assign edge_w = qual & ~prev_q;

    // Remember the last qualified level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= qual;
    end

    // Edge latch: set on a new edge, held until acknowledged, dropped in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= mode_i & ((latch_q & ~ack_i) | edge_w);
    end

    assign pend_o = (mode_i & latch_q) | (~mode_i & qual);
    assign view_o = pend_o & ena_i;

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(latch_q & ~ack_i & mode_i & mode_i))
        |=> ((latch_q & $past(latch_q & ~ack_i & mode_i)) == $past(latch_q & ~ack_i & mode_i)));
    // R11
    ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edge_w & ack_i & mode_i)) |=> (|(latch_q & $past(edge_w & ack_i & mode_i))));
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_i & ~edge_w & mode_i)) |=> ((latch_q & $past(ack_i & ~edge_w)) == '0));
endmodule

// File: rtl/sec_irq_pick.sv
// Priority picker: index of the lowest set bit of the pending-enabled view.
// Assumes NUM_LINES >= 2; the index is zero when nothing is pending.
module sec_irq_pick #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] view_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 valid_o
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (view_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign valid_o = |view_i;

    // R7
    pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (view_i[idx_o] &&
                     ((view_i & ((NUM_LINES'(1) << idx_o) - NUM_LINES'(1))) == '0)));
    // R7
    pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (view_i == '0));
endmodule

// File: rtl/sec_irq_cascade.sv
// Top of the secondary interrupt cascade controller: synchronises lines,
// holds configuration, forms pending state, picks the lowest line and
// drives the cascade and low-power wake outputs. Assumes one clock domain
// for the register port and outputs.
module sec_irq_cascade #(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 low_power,
    output logic                 cascade_irq,
    output logic [IDX_W-1:0]     pick_idx,
    output logic                 pick_valid,
    output logic                 wake_req
);
    logic [NUM_LINES-1:0] synced, ena, mode, sense, wake_mask, ack, pend, view;

    sec_irq_sync #(.NUM_LINES(NUM_LINES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(irq_lines), .sync_o(synced)
    );

    sec_irq_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .view_i(view), .ena_o(ena), .mode_o(mode),
        .sense_o(sense), .wake_o(wake_mask), .ack_o(ack), .rdata_o(reg_rdata)
    );

    sec_irq_pend #(.NUM_LINES(NUM_LINES)) pend_i (
        .clk(clk), .rst_n(rst_n), .line_i(synced), .mode_i(mode),
        .sense_i(sense), .ack_i(ack), .ena_i(ena), .pend_o(pend), .view_o(view)
    );

    sec_irq_pick #(.NUM_LINES(NUM_LINES)) pick_i (
        .clk(clk), .rst_n(rst_n), .view_i(view), .idx_o(pick_idx), .valid_o(pick_valid)
    );

    // Cascade request: any enabled pending line.
    assign cascade_irq = |view;
    // Wake request: wake-masked pending lines, only in low power.
    assign wake_req = low_power & (|(pend & wake_mask));
endmodule

// File: tb/sec_irq_cascade_tb_top.sv
module sec_irq_cascade_tb_top;
    localparam int N  = 32;
    localparam int DW = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          low_power = 1'b0;
    logic          cascade_irq;
    logic [IW-1:0] pick_idx;
    logic          pick_valid;
    logic          wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    logic [N-1:0] m_ena = '0, m_mode = '0, m_sense = '0, m_wake = '0, m_latch = '0, m_in = '0;
    logic         m_lp = 1'b0;

    always #5 clk = ~clk;

    sec_irq_cascade #(.NUM_LINES(N), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .low_power(low_power), .cascade_irq(cascade_irq), .pick_idx(pick_idx),
        .pick_valid(pick_valid), .wake_req(wake_req)
    );

    function automatic logic [N-1:0] exp_pend();
        return (m_mode & m_latch) | (~m_mode & (m_in ^ m_sense));
    endfunction

    function automatic logic [N-1:0] exp_view();
        return exp_pend() & m_ena;
    endfunction

    function automatic logic [IW-1:0] exp_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return IW'(i);
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drive_in(input logic [N-1:0] v);
        logic [N-1:0] oldq, newq;
        oldq = m_in ^ m_sense;
        newq = v ^ m_sense;
        m_latch = m_latch | (newq & ~oldq & m_mode);
        m_in = v;
        @(negedge clk);
        irq_lines = v;
    endtask

    task automatic check_all(input string tag);
        logic [DW-1:0] d;
        logic [N-1:0]  v;
        v = exp_view();
        rd(3'd6, d);
        check({tag, " R6 view"}, d, 32'(v));
        rd(3'd0, d);
        check({tag, " R1 R2 enable"}, d, 32'(m_ena));
        check({tag, " R8 cascade"}, 32'(cascade_irq), 32'(|v));
        check({tag, " R7 valid"}, 32'(pick_valid), 32'(|v));
        if (|v) check({tag, " R7 idx"}, 32'(pick_idx), 32'(exp_idx(v)));
        check({tag, " R9 wake"}, 32'(wake_req), 32'(m_lp & (|(exp_pend() & m_wake))));
    endtask

    // watchdog
    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [N-1:0]  w;
        void'($urandom(32'h5EC1_0A77));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        for (int a = 0; a < 8; a++) begin
            if (a == 5) continue;
            rd(3'(a), d);
            check("R10 reset reg", d, 32'h0);
        end
        check("R10 cascade", 32'(cascade_irq), 32'h0);
        check("R10 valid", 32'(pick_valid), 32'h0);
        check("R10 wake", 32'(wake_req), 32'h0);

        // R1 / R2 set and clear leave others alone
        wr(3'd0, 32'h0000_F0F0); m_ena = 32'h0000_F0F0;
        wr(3'd1, 32'h0000_0101); m_ena |= 32'h0000_0101;
        rd(3'd0, d); check("R1 set", d, 32'h0000_F1F1);
        wr(3'd2, 32'h0000_1010); m_ena &= ~32'h0000_1010;
        rd(3'd0, d); check("R2 clear", d, 32'h0000_E1E1);
        wr(3'd0, 32'hFFFF_FFFF); m_ena = '1;

        // R6 writes to view have no effect
        wr(3'd6, 32'hFFFF_FFFF);
        settle();
        check_all("R6 nowrite");

        // R3 low sense on a level line: quiet low input is pending
        wr(3'd4, 32'h0000_0008); m_sense = 32'h8;
        settle();
        rd(3'd6, d); check("R3 low sense", d, 32'h0000_0008);
        check("R7 idx3", 32'(pick_idx), 32'd3);
        wr(3'd4, 32'h0); m_sense = '0;
        settle();

        // R12 latency on a level line
        @(negedge clk); irq_lines[7] = 1'b1; m_in[7] = 1'b1;
        @(negedge clk); rd(3'd6, d); check("R12 level early", d, 32'h0);
        @(negedge clk); rd(3'd6, d); check("R12 level on", d, 32'h80);
        // R5 ack on active level line: no lasting effect
        wr(3'd5, 32'h80);
        settle();
        rd(3'd6, d); check("R5 level ack", d, 32'h80);
        @(negedge clk); irq_lines[7] = 1'b0; m_in[7] = 1'b0;
        settle();

        // R4 edge line stays pending; R12 edge latency
        wr(3'd3, 32'h20); m_mode = 32'h20;
        @(negedge clk); irq_lines[5] = 1'b1; m_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); rd(3'd6, d); check("R12 edge early", d, 32'h0);
        @(negedge clk); rd(3'd6, d); check("R12 edge on", d, 32'h20);
        m_latch[5] = 1'b1;
        @(negedge clk); irq_lines[5] = 1'b0; m_in[5] = 1'b0;
        settle();
        rd(3'd6, d); check("R4 edge held", d, 32'h20);
        wr(3'd5, 32'h20); m_latch[5] = 1'b0;
        settle();
        rd(3'd6, d); check("R5 edge ack", d, 32'h0);

        // R11 ack in the same cycle as a new edge
        @(negedge clk); irq_lines[5] = 1'b1; m_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h20;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        m_latch[5] = 1'b1;
        settle();
        rd(3'd6, d); check("R11 collide kept", d, 32'h20);
        wr(3'd5, 32'h20); m_latch[5] = 1'b0;
        settle();
        rd(3'd6, d); check("R11 later ack", d, 32'h0);

        // R9 wake independent of enables
        wr(3'd0, 32'h0); m_ena = '0;
        wr(3'd7, 32'h80); m_wake = 32'h80;
        drive_in(m_in | 32'h80);
        settle();
        check("R9 wake off", 32'(wake_req), 32'h0);
        @(negedge clk); low_power = 1'b1; m_lp = 1'b1;
        #1 check("R9 wake on", 32'(wake_req), 32'h1);
        check("R8 cascade masked", 32'(cascade_irq), 32'h0);

        // random traffic
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 11);
            w = $urandom;
            case (op)
                0, 1, 2: drive_in(w);
                3: begin wr(3'd0, w); m_ena = w; end
                4: begin wr(3'd1, w); m_ena |= w; end
                5: begin wr(3'd2, w); m_ena &= ~w; end
                6: begin wr(3'd3, w); m_mode = w; m_latch &= w; end
                7: begin
                    logic [N-1:0] oq, nq;
                    oq = m_in ^ m_sense; nq = m_in ^ w;
                    m_latch |= nq & ~oq & m_mode;
                    wr(3'd4, w); m_sense = w;
                end
                8, 9: begin wr(3'd5, w); m_latch &= ~w; end
                10: begin wr(3'd7, w); m_wake = w; end
                default: begin
                    @(negedge clk); m_lp = w[0]; low_power = w[0];
                end
            endcase
            settle();
            check_all("rand");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule